// File: doc/BRIEF.md
# Dual-Bank Flash Operation Sequencer

This block is the command-side gatekeeper of a NOR-style flash array whose blocks are split into two banks. Each cycle it may receive one decoded request (read, program, erase, suspend or resume) with a target block index. It decides whether the array may carry out the request, given what each bank is doing. Program and erase run for a time set by an external timer model, which signals the end of each operation with a per-bank completion pulse.

Reads go to one bank while the other programs or erases. An erase can be paused so that other blocks of the same bank can be read or programmed, and then restarted. A block is placed in a bank by comparing its index with a fixed boundary parameter. The small parameter blocks can therefore sit at either end of the map.

Top module: `flash_bank_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `bank_busy`, `grant`, `reject`, `err_busy` and `suspended` are all 0.
- R2: Blocks with index below `BANK_SPLIT` (default 8) belong to bank A, whose flag is `bank_busy[0]`. Blocks from `BANK_SPLIT` to `NUM_BLOCKS-1` (default 38) belong to bank B, whose flag is `bank_busy[1]`. A read, program or erase to an index of `NUM_BLOCKS` or more is rejected with `err_busy`=0.
- R3: Op codes on `req_op` are 0 none, 1 read, 2 program, 3 erase, 4 suspend and 5 resume. `grant`, `reject` and `err_busy` are registered and report on the clock edge that takes the request. `bank_busy` and `suspended` change on that same edge.
- R4: A program or erase to an idle bank is granted. That bank's busy flag is then 1 until a pulse on `op_done` for that bank.
- R5: A read to a bank that is idle is granted, even while the other bank is busy. A read to a busy bank is rejected with `err_busy`=0.
- R6: A program or erase to a busy bank is rejected with `err_busy`=1.
- R7: A suspend aimed at a bank that is erasing is granted. `suspended` becomes 1 and that bank's busy flag becomes 0. If the bank's `op_done` pulses in the same cycle, the erase ends instead: the suspend is not granted and `suspended` stays 0.
- R8: While an erase is suspended, reads and programs to other blocks of the same bank are granted. Such a program makes the bank busy. Its `op_done` pulse returns the bank to idle-suspended with `suspended` still 1.
- R9: While an erase is suspended, a read or program to the suspended block is rejected, and so is any erase to that bank. All of these carry `err_busy`=0.
- R10: A resume to a suspended bank that is not programming is granted. It clears `suspended` and sets that bank's busy flag. The erase then ends on the next `op_done` pulse for that bank.
- R11: The following requests give neither grant nor reject and change no state: a suspend when the target bank is not erasing, and a resume when the target bank is not idle-suspended. An `op_done` pulse to an idle or idle-suspended bank also changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation code (see R3) |
| req_blk | input | BLK_W (6) | Target block index |
| op_done | input | 2 | Completion pulse per bank, bit 0 bank A |
| bank_busy | output | 2 | Bank has a program or erase running |
| grant | output | 1 | Last request accepted |
| reject | output | 1 | Last request refused |
| err_busy | output | 1 | Refused write to a busy bank |
| suspended | output | 1 | An erase is suspended in some bank |

## Verification
Every result is due exactly one clock edge after its stimulus. The verdict flags, the bank busy flags and the suspend flag all come from registers loaded on the edge that takes the request or the completion pulse. The bench therefore drives inputs on the falling edge and waits one rising edge. It samples on the following falling edge and then withdraws the request, so each check sees exactly one cycle's verdict. The bench does not hold the flags sampled on the edge after that one, because the verdict flags go back to 0 by then.

// File: rtl/fbs_pkg.sv
// Shared types of the dual-bank flash sequencer.
package fbs_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_READ    = 3'd1,
        OP_PROG    = 3'd2,
        OP_ERASE   = 3'd3,
        OP_SUSPEND = 3'd4,
        OP_RESUME  = 3'd5
    } fbs_op_e;

    typedef enum logic [2:0] {
        BK_IDLE      = 3'd0,
        BK_PROG      = 3'd1,
        BK_ERASE     = 3'd2,
        BK_SUSP      = 3'd3,
        BK_SUSP_PROG = 3'd4
    } fbs_bank_st_e;

    localparam int NUM_BANKS = 2;
endpackage

// File: rtl/fbs_bank_map.sv
// Block-to-bank mapper.
// What it does: places a block in bank A (0) when its index is below BANK_SPLIT,
// otherwise in bank B (1), and flags indices outside the array.
// Assumes: 0 < BANK_SPLIT < NUM_BLOCKS <= 2**BLK_W.
module fbs_bank_map #(
    parameter int NUM_BLOCKS = 39,
    parameter int BANK_SPLIT = 8,
    parameter int BLK_W      = 6
) (
    input  logic [BLK_W-1:0] blk,
    output logic             in_range,
    output logic             bank_sel
);
    localparam logic [BLK_W:0] LIMIT = (BLK_W+1)'(NUM_BLOCKS);
    localparam logic [BLK_W:0] SPLIT = (BLK_W+1)'(BANK_SPLIT);

    // Purpose: compare the index with the array size and the bank boundary.
    always_comb begin
        in_range = {1'b0, blk} < LIMIT;
        bank_sel = {1'b0, blk} >= SPLIT;
    end
endmodule

// File: rtl/fbs_bank_ctrl.sv
// Per-bank operation controller.
// What it does: tracks one bank through idle, program, erase, suspended erase
// and program-during-suspend, and gives a verdict for a request aimed at it.
// Assumes: sel is high only for an in-range request of this bank. The verdict
// uses the state at the start of the cycle. A completion pulse ends the
// running operation unless a granted transition takes priority, which can
// only happen from states where the pulse has no effect.
module fbs_bank_ctrl
    import fbs_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  fbs_op_e          op,
    input  logic [BLK_W-1:0] blk,
    input  logic             done,
    output logic             grant_o,
    output logic             reject_o,
    output logic             err_o,
    output logic             busy_o,
    output logic             susp_o
);
    fbs_bank_st_e     state, state_nxt;
    logic [BLK_W-1:0] eblk, eblk_nxt;
    logic             hit_susp_blk;

    assign hit_susp_blk = (blk == eblk);

    // Purpose: decide the verdict for this bank and the next state.
    always_comb begin
        grant_o   = 1'b0;
        reject_o  = 1'b0;
        err_o     = 1'b0;
        state_nxt = state;
        eblk_nxt  = eblk;
        // completion pulse first; a grant below overrides it
        case (state)
            BK_PROG, BK_ERASE: if (done) state_nxt = BK_IDLE;
            BK_SUSP_PROG:      if (done) state_nxt = BK_SUSP;
            default: ;
        endcase
        if (sel) begin
            case (state)
                BK_IDLE: begin
                    case (op)
                        OP_READ: grant_o = 1'b1;
                        OP_PROG: begin
                            grant_o   = 1'b1;
                            state_nxt = BK_PROG;
                        end
                        OP_ERASE: begin
                            grant_o   = 1'b1;
                            state_nxt = BK_ERASE;
                            eblk_nxt  = blk;
                        end
                        default: ;
                    endcase
                end
                BK_PROG, BK_SUSP_PROG: begin
                    case (op)
                        OP_READ: reject_o = 1'b1;
                        OP_PROG, OP_ERASE: begin
                            reject_o = 1'b1;
                            err_o    = 1'b1;
                        end
                        default: ;
                    endcase
                end
                BK_ERASE: begin
                    case (op)
                        OP_READ: reject_o = 1'b1;
                        OP_PROG, OP_ERASE: begin
                            reject_o = 1'b1;
                            err_o    = 1'b1;
                        end
                        OP_SUSPEND: if (!done) begin
                            grant_o   = 1'b1;
                            state_nxt = BK_SUSP;
                        end
                        default: ;
                    endcase
                end
                BK_SUSP: begin
                    case (op)
                        OP_READ: begin
                            grant_o  = !hit_susp_blk;
                            reject_o = hit_susp_blk;
                        end
                        OP_PROG: begin
                            grant_o  = !hit_susp_blk;
                            reject_o = hit_susp_blk;
                            if (!hit_susp_blk) state_nxt = BK_SUSP_PROG;
                        end
                        OP_ERASE: reject_o = 1'b1;
                        OP_RESUME: begin
                            grant_o   = 1'b1;
                            state_nxt = BK_ERASE;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Purpose: hold the bank state and the block whose erase is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            eblk  <= '0;
        end else begin
            state <= state_nxt;
            eblk  <= eblk_nxt;
        end
    end

    assign busy_o = (state == BK_PROG) || (state == BK_ERASE) || (state == BK_SUSP_PROG);
    assign susp_o = (state == BK_SUSP) || (state == BK_SUSP_PROG);

    // R7: a suspension can only begin from a running erase
    a_r7_susp_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_o) |-> $past(busy_o));
    // R10: leaving suspension always resumes a busy erase
    a_r10_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_o) |-> busy_o);
    // R4: a bank only leaves busy after a completion pulse
    a_r4_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !susp_o) |-> $past(done));
endmodule

// File: rtl/flash_bank_sequencer.sv
// Dual-bank flash operation sequencer (top).
// What it does: routes each in-range request to the controller of its bank,
// rejects out-of-range accesses and registers the verdict flags.
// Assumes: at most one request per cycle; op_done pulses come from an external
// timer model, one bit per bank.
module flash_bank_sequencer
    import fbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 39,
    parameter int BANK_SPLIT = 8,
    parameter int BLK_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [BLK_W-1:0]     req_blk,
    input  logic [NUM_BANKS-1:0] op_done,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic                 grant,
    output logic                 reject,
    output logic                 err_busy,
    output logic                 suspended
);
    fbs_op_e              op;
    logic                 in_range, bank_sel, is_access;
    logic [NUM_BANKS-1:0] g, r, e, busy_v, susp_v;
    logic                 grant_d, reject_d, err_d;

    assign op        = fbs_op_e'(req_op);
    assign is_access = (op == OP_READ) || (op == OP_PROG) || (op == OP_ERASE);

    fbs_bank_map #(.NUM_BLOCKS(NUM_BLOCKS), .BANK_SPLIT(BANK_SPLIT), .BLK_W(BLK_W)) u_map (
        .blk(req_blk), .in_range(in_range), .bank_sel(bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_b;
        assign sel_b = req_valid && in_range && (bank_sel == b[0]);
        fbs_bank_ctrl #(.BLK_W(BLK_W)) u_ctrl (
            .clk(clk), .rst_n(rst_n), .sel(sel_b), .op(op), .blk(req_blk),
            .done(op_done[b]), .grant_o(g[b]), .reject_o(r[b]), .err_o(e[b]),
            .busy_o(busy_v[b]), .susp_o(susp_v[b])
        );
    end

    // Purpose: merge the bank verdicts with the out-of-range rejection.
    always_comb begin
        grant_d  = |g;
        reject_d = (|r) || (req_valid && !in_range && is_access);
        err_d    = |e;
    end

    // Purpose: register the verdict flags one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant    <= 1'b0;
            reject   <= 1'b0;
            err_busy <= 1'b0;
        end else begin
            grant    <= grant_d;
            reject   <= reject_d;
            err_busy <= err_d;
        end
    end

    assign bank_busy = busy_v;
    assign suspended = |susp_v;

    // R3: a verdict is never both accept and refuse
    a_r3_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));
    // R6: the busy error only comes with a refusal
    a_r6_err_with_reject: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |-> reject);
    // R11: suspend and resume are never refused
    a_r11_no_refuse_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd4 || req_op == 3'd5)) |=> !reject);
    // R2: out-of-range requests are never accepted
    a_r2_range_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_range) |=> !grant);
endmodule

// File: tb/flash_bank_sequencer_test.sv
module flash_bank_sequencer_test;
    localparam int NB = 39, SPL = 8, BW = 6;
    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [BW-1:0] req_blk = '0;
    logic [1:0] op_done = '0, bank_busy;
    logic grant, reject, err_busy, suspended;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_bank_sequencer #(.NUM_BLOCKS(NB), .BANK_SPLIT(SPL), .BLK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .op_done(op_done), .bank_busy(bank_busy),
        .grant(grant), .reject(reject), .err_busy(err_busy), .suspended(suspended)
    );

    function automatic int bank_of(int b);
        return (b < SPL) ? 0 : 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // verdict: {grant,reject,err}
    task automatic expect_v(input string req, input int g, input int r, input int e);
        int act = {grant, reject, err_busy};
        int exp = {g[0], r[0], e[0]};
        chk(act == exp, req, act, exp);
    endtask

    task automatic expect_s(input string req, input int busy, input int susp);
        int act = {bank_busy, suspended};
        int exp = {busy[1:0], susp[0]};
        chk(act == exp, req, act, exp);
    endtask

    // one request with optional done pulse; result sampled one edge later
    task automatic issue(input int op, input int blk, input int dn);
        @(negedge clk);
        req_valid = (op != 0);
        req_op    = op[2:0];
        req_blk   = blk[BW-1:0];
        op_done   = dn[1:0];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = '0;
        op_done   = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_v("R1 verdict", 0, 0, 0);
        expect_s("R1 state", 0, 0);

        // R2 R5: idle sweep over every index
        for (int b = 0; b < (1 << BW); b++) begin
            issue(1, b, 0);
            if (b < NB) expect_v("R2 R5 idle read", 1, 0, 0);
            else        expect_v("R2 out of range", 0, 1, 0);
        end
        issue(2, NB, 0);
        expect_v("R2 out of range program", 0, 1, 0);
        expect_s("R2 no state change", 0, 0);

        // R4 R5 R6: write in each bank, read sweep across both
        for (int t = 0; t < 2; t++) begin
            int pb = (t == 0) ? 0 : 20;
            int bk = bank_of(pb);
            int op = (t == 0) ? 2 : 3;
            issue(op, pb, 0);
            expect_v("R4 write granted", 1, 0, 0);
            expect_s("R4 bank busy", 1 << bk, 0);
            for (int b = 0; b < NB; b++) begin
                issue(1, b, 0);
                if (bank_of(b) != bk) expect_v("R5 cross-bank read", 1, 0, 0);
                else                  expect_v("R5 same-bank read", 0, 1, 0);
            end
            issue(2, (bk == 0) ? 5 : 30, 0);
            expect_v("R6 program busy bank", 0, 1, 1);
            issue(3, (bk == 0) ? 7 : 8, 0);
            expect_v("R6 erase busy bank", 0, 1, 1);
            issue(0, 0, 1 << (1 - bk));
            expect_s("R11 done to idle bank", 1 << bk, 0);
            issue(0, 0, 1 << bk);
            expect_s("R4 done clears busy", 0, 0);
        end

        // R11: suspend / resume with nothing to act on
        issue(4, 10, 0);
        expect_v("R11 stray suspend", 0, 0, 0);
        expect_s("R11 stray suspend state", 0, 0);
        issue(5, 2, 0);
        expect_v("R11 stray resume", 0, 0, 0);
        expect_s("R11 stray resume state", 0, 0);

        // R7 R8 R9 R10: suspend cycle on bank B, erasing block 10
        issue(3, 10, 0);
        expect_s("R4 erase busy", 2, 0);
        issue(4, 12, 0);
        expect_v("R7 suspend granted", 1, 0, 0);
        expect_s("R7 suspended state", 0, 1);
        issue(0, 0, 2);
        expect_s("R11 done while suspended", 0, 1);
        for (int b = SPL; b < NB; b++) begin
            issue(1, b, 0);
            if (b == 10) expect_v("R9 read suspended block", 0, 1, 0);
            else         expect_v("R8 read in suspended bank", 1, 0, 0);
        end
        issue(2, 10, 0);
        expect_v("R9 program suspended block", 0, 1, 0);
        issue(3, 11, 0);
        expect_v("R9 erase during suspend", 0, 1, 0);
        issue(2, 15, 0);
        expect_v("R8 program during suspend", 1, 0, 0);
        expect_s("R8 busy while suspended", 2, 1);
        issue(1, 16, 0);
        expect_v("R8 read while suspend-program", 0, 1, 0);
        issue(5, 12, 0);
        expect_v("R11 resume during program", 0, 0, 0);
        expect_s("R11 resume during program state", 2, 1);
        issue(1, 3, 0);
        expect_v("R5 other bank during suspend", 1, 0, 0);
        issue(0, 0, 2);
        expect_s("R8 done back to suspended", 0, 1);
        issue(5, 20, 0);
        expect_v("R10 resume granted", 1, 0, 0);
        expect_s("R10 resumed busy", 2, 0);
        issue(1, 10, 0);
        expect_v("R10 erasing bank read", 0, 1, 0);
        issue(0, 0, 2);
        expect_s("R10 erase completes", 0, 0);

        // R7: suspend coinciding with completion
        issue(3, 3, 0);
        issue(4, 3, 1);
        expect_v("R7 suspend with done", 0, 0, 0);
        expect_s("R7 suspend with done state", 0, 0);

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule